// File: doc/BRIEF.md
# Paged nonvolatile write buffer controller

This block is a synchronous behavioural model of the write engine of a byte-wide paged nonvolatile memory. A host presents bytes through three active-low strobes (chip select, read enable, write enable) like a static RAM. Accepted bytes collect in a page latch of `1 << SLOT_W` slots. The first byte fixes the page, and every later byte must target that same page. When no further byte arrives for `LOAD_TMO` clock cycles, loading closes and a programming period of `WR_CYC` cycles begins. During that period `busy` is high and the block ignores new writes. At the end of the period, only the slots the host loaded are copied into a register-based backing array, and the latch empties.

Every time is counted in system clock cycles. The programming length is picked by a parameter that selects either the slow or the fast cycle count. A registered read port returns array contents so that commits can be observed. Read timing and supply behaviour are outside this model.

Top module: `pgbuf_ctrl`

## Requirements
- R1: After reset, `busy` and `page_viol` are 0, `rd_data` is 0 and every array byte reads back as all ones (8'hFF).
- R2: A byte is accepted when `ce_n` and `we_n` are both low with `oe_n` high, in either order of falling, for at least `GLITCH_MIN` clock edges. The strobe ends with `ce_n` or `we_n` returning high while `oe_n` is still high.
- R3: A strobe that is active for fewer than `GLITCH_MIN` edges is not accepted. A strobe that ends because `oe_n` went low is not accepted either.
- R4: The address is the value present at the first edge of the active strobe. The data is the value of `din` at the edge where the strobe is seen to end.
- R5: Each accepted byte restarts the load window. `busy` rises at the `LOAD_TMO`-th clock edge after the last accepted byte, counting the edge that accepted it as edge 0.
- R6: `busy` stays high for exactly `WR_CYC` clock cycles, where `WR_CYC` is `WR_CYC_FAST` when `FAST_PROG` is 1 and `WR_CYC_SLOW` otherwise. The commit happens on the edge where `busy` falls.
- R7: Only slots loaded during the load period are written to the array. The other bytes of that page keep their previous contents.
- R8: Slots may be loaded in any order. If one slot is loaded twice in a load period, the later byte is the one committed.
- R9: Address bits `[ADDR_W-1:SLOT_W]` form the page and bits `[SLOT_W-1:0]` form the slot. During a load, a byte whose page differs from the first byte's page is dropped, and it sets `page_viol`. `page_viol` stays set until reset and does not restart the load window.
- R10: While `busy` is high, accepted strobes change nothing. After the commit the latch is empty, so the next load writes only its own slots.
- R11: All `1 << SLOT_W` slots of a page can be loaded in one load period and committed together.
- R12: `rd_data` is registered. One edge after `ce_n` and `oe_n` are low with `we_n` high, it holds the array byte at `addr` as it was before that edge. Otherwise it holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low; low inhibits writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, slot in the lower SLOT_W bits |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | High during the programming period |
| page_viol | output | 1 | Sticky flag for a byte dropped because it targeted another page |

## Verification
Some properties are checked by assertions on every cycle:
- an accepted byte always comes from a qualified strobe;
- a load timer expiry is a single pulse;
- `busy` only rises out of a load and lasts exactly the programming length;
- a wrong-page byte or any byte during programming leaves the latch untouched;
- `page_viol` never clears;
- at most one new slot enters the latch per cycle.

Only the bench scenarios can show the rest, because they need the array content read back:
- the right data lands in the right slot;
- untouched slots keep their old bytes;
- overwrites resolve to the later value;
- short or aborted strobes leave no trace;
- a commit does not leak stale slots into the next page.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_LOAD = 2'd1,
      PG_PROG = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgbuf_strobe.sv
module pgbuf_strobe #(
   parameter int ADDR_W     = 9,
   parameter int DATA_W     = 8,
   parameter int GLITCH_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              byte_vld,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [DATA_W-1:0] byte_data
);
   localparam int LEN_W = $clog2(GLITCH_MIN + 1);

   if (GLITCH_MIN < 1) begin : g_bad_glitch
      $error("pgbuf_strobe: GLITCH_MIN must be at least 1");
   end

   logic              wact;
   logic              wact_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] addr_q;

   // write window: select and write low, read enable high
   assign wact = !ce_n && !we_n && oe_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wact_q <= 1'b0;
         len_q  <= '0;
         addr_q <= '0;
      end else begin
         wact_q <= wact;
         if (wact && !wact_q) begin
            addr_q <= addr;
            len_q  <= LEN_W'(1);
         end else if (wact && (len_q != LEN_W'(GLITCH_MIN))) begin
            len_q <= len_q + LEN_W'(1);
         end
      end
   end

   // end of window while read enable is still high, long enough
   assign byte_vld  = wact_q && !wact && oe_n && (len_q >= LEN_W'(GLITCH_MIN));
   assign byte_addr = addr_q;
   assign byte_data = din;

   // R2: an accepted byte follows a qualified write window
   a_r2_strobe_was_active : assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(!ce_n && !we_n && oe_n));
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic enable,
   output logic expire
);
   localparam int CNT_W = $clog2(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("pgbuf_timer: LIMIT must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (enable && (cnt != CNT_W'(LIMIT - 1))) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign expire = enable && !restart && (cnt == CNT_W'(LIMIT - 1));

   // R5 / R6: the owner leaves the counting state on expiry, so it is one pulse
   a_r5_expire_single : assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);
endmodule

// File: rtl/pgbuf_latch.sv
module pgbuf_latch #(
   parameter int SLOT_W = 6,
   parameter int DATA_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [SLOT_W-1:0]                wr_slot,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic                             clr,
   output logic [(1<<SLOT_W)-1:0]           mask_o,
   output logic [(1<<SLOT_W)-1:0][DATA_W-1:0] data_o
);
   localparam int SLOTS = 1 << SLOT_W;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic              used_q;
      logic [DATA_W-1:0] val_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            used_q <= 1'b0;
            val_q  <= '0;
         end else if (clr) begin
            used_q <= 1'b0;
         end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
            used_q <= 1'b1;
            val_q  <= wr_data;
         end
      end

      assign mask_o[s] = used_q;
      assign data_o[s] = val_q;
   end

   // R8: a single slot enters the latch per cycle at most
   a_r8_one_slot_per_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(mask_o) <= $countones($past(mask_o)) + 1));
endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
   import pgbuf_pkg::*;
#(
   parameter int PAGE_W      = 3,
   parameter int SLOT_W      = 6,
   parameter int DATA_W      = 8,
   parameter int GLITCH_MIN  = 2,
   parameter int LOAD_TMO    = 7500,
   parameter int WR_CYC_SLOW = 500000,
   parameter int WR_CYC_FAST = 150000,
   parameter bit FAST_PROG   = 1'b0,
   localparam int ADDR_W     = PAGE_W + SLOT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              page_viol
);
   localparam int SLOTS  = 1 << SLOT_W;
   localparam int PAGES  = 1 << PAGE_W;
   localparam int WR_CYC = FAST_PROG ? WR_CYC_FAST : WR_CYC_SLOW;
   localparam int BL_W   = $clog2(WR_CYC + 2);

   if (PAGES * SLOTS > 4096) begin : g_bad_depth
      $error("pgbuf_ctrl: backing array too large for a register model");
   end
   if (SLOT_W < 1 || PAGE_W < 1) begin : g_bad_split
      $error("pgbuf_ctrl: page and slot fields need at least one bit");
   end

   // ---------------- strobe qualification ----------------
   logic              byte_vld;
   logic [ADDR_W-1:0] byte_addr;
   logic [DATA_W-1:0] byte_data;

   pgbuf_strobe #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .GLITCH_MIN(GLITCH_MIN)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .addr     (addr),
      .din      (din),
      .byte_vld (byte_vld),
      .byte_addr(byte_addr),
      .byte_data(byte_data)
   );

   logic [PAGE_W-1:0] byte_page;
   logic [SLOT_W-1:0] byte_slot;
   assign byte_page = byte_addr[ADDR_W-1:SLOT_W];
   assign byte_slot = byte_addr[SLOT_W-1:0];

   // ---------------- sequencing ----------------
   pg_state_e         state;
   logic [PAGE_W-1:0] page_q;
   logic              same_page;
   logic              lat_wr;
   logic              viol_set;
   logic              ld_exp;
   logic              pg_exp;

   assign same_page = (byte_page == page_q);
   assign lat_wr    = byte_vld && ((state == PG_IDLE) || ((state == PG_LOAD) && same_page));
   assign viol_set  = byte_vld && (state == PG_LOAD) && !same_page;

   pgbuf_timer #(.LIMIT(LOAD_TMO)) u_load_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(lat_wr),
      .enable (state == PG_LOAD),
      .expire (ld_exp)
   );

   pgbuf_timer #(.LIMIT(WR_CYC)) u_prog_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(ld_exp),
      .enable (state == PG_PROG),
      .expire (pg_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PG_IDLE;
         page_q    <= '0;
         page_viol <= 1'b0;
      end else begin
         if (viol_set) page_viol <= 1'b1;
         unique case (state)
            PG_IDLE: if (lat_wr) begin
               state  <= PG_LOAD;
               page_q <= byte_page;
            end
            PG_LOAD: if (ld_exp) state <= PG_PROG;
            PG_PROG: if (pg_exp) state <= PG_IDLE;
            default: state <= PG_IDLE;
         endcase
      end
   end

   assign busy = (state == PG_PROG);

   // ---------------- page latch ----------------
   logic [SLOTS-1:0]             lmask;
   logic [SLOTS-1:0][DATA_W-1:0] ldata;

   pgbuf_latch #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (lat_wr),
      .wr_slot(byte_slot),
      .wr_data(byte_data),
      .clr    (pg_exp),
      .mask_o (lmask),
      .data_o (ldata)
   );

   // ---------------- backing array, one row per page ----------------
   logic [SLOTS-1:0][DATA_W-1:0] rows [PAGES];

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      logic [SLOTS-1:0][DATA_W-1:0] row_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_q <= '1;
         end else if (pg_exp && (page_q == PAGE_W'(p))) begin
            for (int s = 0; s < SLOTS; s++) begin
               if (lmask[s]) row_q[s] <= ldata[s];
            end
         end
      end

      assign rows[p] = row_q;
   end

   // ---------------- read port ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (!ce_n && !oe_n && we_n) begin
         rd_data <= rows[addr[ADDR_W-1:SLOT_W]][addr[SLOT_W-1:0]];
      end else begin
         rd_data <= '0;
      end
   end

   // ---------------- assertions ----------------
   logic [BL_W-1:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_len <= '0;
      else        busy_len <= busy ? busy_len + BL_W'(1) : '0;
   end

   // R6: programming lasts exactly WR_CYC cycles
   a_r6_busy_len : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == BL_W'(WR_CYC)));

   // R5: programming is entered only from a load period
   a_r5_busy_from_load : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(state) == PG_LOAD));

   // R9: the violation flag never clears
   a_r9_viol_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      page_viol |=> page_viol);

   // R9: a wrong-page byte leaves the latch untouched
   a_r9_page_lock : assert property (@(posedge clk) disable iff (!rst_n)
      (state == PG_LOAD && byte_vld && !same_page) |=> ($stable(lmask) && $stable(ldata)));

   // R10: nothing enters the latch while programming
   a_r10_busy_freeze : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pg_exp) |=> ($stable(lmask) && $stable(ldata)));

   // R7: a load period always holds at least one slot
   a_r7_load_nonempty : assert property (@(posedge clk) disable iff (!rst_n)
      (state == PG_LOAD) |-> (lmask != '0));
endmodule

// File: tb/pgbuf_ctrl_tb_top.sv
module pgbuf_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PAGE_W     = 3;
   localparam int SLOT_W     = 6;
   localparam int DATA_W     = 8;
   localparam int GLITCH     = 2;
   localparam int LTMO       = 20;
   localparam int WCYC       = 30;
   localparam int ADDR_W     = PAGE_W + SLOT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] din = '0;
   logic [DATA_W-1:0] rd_data;
   logic              busy, page_viol;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgbuf_ctrl #(
      .PAGE_W(PAGE_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W), .GLITCH_MIN(GLITCH),
      .LOAD_TMO(LTMO), .WR_CYC_SLOW(WCYC + 40), .WR_CYC_FAST(WCYC), .FAST_PROG(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .rd_data(rd_data), .busy(busy), .page_viol(page_viol)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_mem[int];
   int m_buf[int];
   int m_state, m_page, m_idle, m_prog, m_len, m_addr;
   bit m_prev, m_wact, m_acc, m_viol;
   int exp_rd;

   function automatic int mem_rd(input int a);
      return m_mem.exists(a) ? m_mem[a] : 8'hFF;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mem.delete(); m_buf.delete();
         m_state = 0; m_page = 0; m_idle = 0; m_prog = 0; m_len = 0; m_addr = 0;
         m_prev = 0; m_viol = 0; exp_rd = 0;
      end else begin
         m_wact = !ce_n && !we_n && oe_n;
         m_acc  = m_prev && !m_wact && oe_n && (m_len >= GLITCH);
         exp_rd = (!ce_n && !oe_n && we_n) ? mem_rd(int'(addr)) : 0;
         case (m_state)
            0: if (m_acc) begin
                  m_buf[m_addr % 64] = din; m_page = m_addr / 64; m_idle = 0; m_state = 1;
               end
            1: begin
                  if (m_acc && (m_addr / 64 == m_page)) begin
                     m_buf[m_addr % 64] = din; m_idle = 0;
                  end else begin
                     if (m_acc) m_viol = 1;
                     if (m_idle == LTMO - 1) begin m_state = 2; m_prog = 0; end
                     else m_idle++;
                  end
               end
            default: begin
                  if (m_prog == WCYC - 1) begin
                     foreach (m_buf[s]) m_mem[m_page * 64 + s] = m_buf[s];
                     m_buf.delete();
                     m_state = 0;
                  end else m_prog++;
               end
         endcase
         if (m_wact) begin
            if (!m_prev) begin m_addr = int'(addr); m_len = 1; end
            else m_len++;
         end
         m_prev = m_wact;
      end
   end

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == (m_state == 2), "R5/R6 busy timing", busy, m_state == 2);
         chk(page_viol == m_viol, "R9 page_viol", page_viol, m_viol);
         chk(rd_data == exp_rd[7:0], "R12 rd_data", rd_data, exp_rd);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input int a, input int d, input int len, input bit ce_ctl,
                     input int a2 = -1, input int d2 = -1);
      @(negedge clk);
      addr = ADDR_W'(a); din = DATA_W'(d); oe_n = 1'b1;
      if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
      @(negedge clk);
      if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (i == 0 && a2 >= 0) addr = ADDR_W'(a2);
         if (i == 0 && d2 >= 0) din = DATA_W'(d2);
      end
      if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      @(negedge clk);
      addr = ADDR_W'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      @(negedge clk);
      chk(rd_data == DATA_W'(exp), tag, rd_data, exp);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wait_busy();
      while (m_state != 2) @(negedge clk);
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (m_state != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1 busy at reset", busy, 0);
      chk(page_viol == 1'b0, "R1 page_viol at reset", page_viol, 0);
      chk(rd_data == '0, "R1 rd_data at reset", rd_data, 0);
      rst_n = 1'b1;
      rd_chk(5, 8'hFF, "R1 erased array");

      // R2 both strobe orders, R8 overwrite, R7 untouched slots
      wr(64 + 3, 8'hA5, 2, 1'b0);
      wr(64 + 10, 8'h3C, 3, 1'b1);
      wr(64 + 3, 8'h5A, 2, 1'b0);
      chk(busy == 1'b0, "R5 not busy inside load window", busy, 0);
      wait_busy();
      chk(busy == 1'b1, "R5 busy after load timeout", busy, 1);
      wait_done();
      rd_chk(64 + 3, 8'h5A, "R8 later byte wins");
      rd_chk(64 + 10, 8'h3C, "R2 chip-select controlled write");
      rd_chk(64 + 4, 8'hFF, "R7 unloaded slot kept");

      // R3 short strobe and aborted strobe
      wr(128 + 0, 8'h77, 1, 1'b0);
      repeat (LTMO + 5) @(negedge clk);
      chk(busy == 1'b0, "R3 short strobe starts nothing", busy, 0);
      @(negedge clk);
      oe_n = 1'b1; ce_n = 1'b0; addr = ADDR_W'(128 + 2); din = 8'h66;
      @(negedge clk); we_n = 1'b0;
      repeat (3) @(negedge clk);
      oe_n = 1'b0;
      @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
      @(negedge clk); oe_n = 1'b1;
      repeat (LTMO + 5) @(negedge clk);
      chk(busy == 1'b0, "R3 read-enable abort starts nothing", busy, 0);
      rd_chk(128 + 0, 8'hFF, "R3 short strobe left array");
      rd_chk(128 + 2, 8'hFF, "R3 aborted strobe left array");

      // R4 address at start, data at end
      wr(320 + 7, 8'h12, 3, 1'b0, 320 + 9, 8'h34);
      wait_done();
      rd_chk(320 + 7, 8'h34, "R4 start address with end data");
      rd_chk(320 + 9, 8'hFF, "R4 late address ignored");

      // R9 page lock
      wr(128 + 1, 8'h11, 2, 1'b0);
      wr(192 + 1, 8'h22, 2, 1'b0);
      @(negedge clk);
      chk(page_viol == 1'b1, "R9 violation flagged", page_viol, 1);
      wait_done();
      rd_chk(128 + 1, 8'h11, "R9 locked page committed");
      rd_chk(192 + 1, 8'hFF, "R9 foreign page dropped");
      chk(page_viol == 1'b1, "R9 flag sticky", page_viol, 1);

      // R10 writes during busy ignored
      wr(256 + 0, 8'h44, 2, 1'b0);
      wait_busy();
      wr(256 + 2, 8'h99, 2, 1'b0);
      wait_done();
      rd_chk(256 + 0, 8'h44, "R10 committed byte");
      rd_chk(256 + 2, 8'hFF, "R10 busy write ignored");

      // R10 latch cleared after commit
      wr(384 + 1, 8'h61, 2, 1'b1);
      wait_done();
      wr(448 + 2, 8'h72, 2, 1'b0);
      wait_done();
      rd_chk(448 + 2, 8'h72, "R10 next load commits");
      rd_chk(448 + 1, 8'hFF, "R10 no stale slot");

      // R11 full page in descending order
      for (int s = 63; s >= 0; s--) wr(s, (s + 8'h40) & 8'hFF, 2, s[0]);
      wait_done();
      rd_chk(0, 8'h40, "R11 full page slot 0");
      rd_chk(31, 8'h5F, "R11 full page slot 31");
      rd_chk(63, 8'h7F, "R11 full page slot 63");

      // R12 no read strobe gives zero
      @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; addr = '0;
      @(negedge clk);
      chk(rd_data == '0, "R12 deselected read is zero", rd_data, 0);
      oe_n = 1'b1;
      repeat (3) @(negedge clk);

      summary();
      $finish;
   end
endmodule